// File: doc/BRIEF.md
# Programmable Strobe Clock Generator

The block turns the system bus clock into a slower programmable clock or strobe. Two dividers are chained. The first is a prescaler with a programmable limit. It sends one tick for every N+1 bus clocks. The second is a 16-bit match counter. It advances once per tick. When it reaches a programmed terminal value it restarts from zero and reports a match.

On each match, the strobe output does one of two things, chosen by a mode bit:

- It goes active for one prescaled period (pulse mode).
- It changes its level (toggle mode).

A polarity bit inverts the output. Software controls the block through a small register window. It sets the prescale limit, the terminal value and the control bits. It starts, stops and clears the dividers. It reads a sticky match flag, which can raise an interrupt.

A control state machine has two states. `ST_STOPPED` is entered at reset. `ST_RUNNING` is the other. The `START` transition moves from `ST_STOPPED` to `ST_RUNNING` on a control write with the run bit at 1. The `HALT` transition moves from `ST_RUNNING` to `ST_STOPPED` on a control write with the run bit at 0. Any other cycle keeps the current state. A clear request is a separate one-cycle action. It can come in either state.

Top module: `strobe_clock_gen`

## Requirements
- R1: Register window, decoded from `bus_addr`:
  - Address 0 holds the prescale limit P in bits [7:0].
  - Address 1 holds the terminal value T in bits [15:0].
  - Address 2 is control: bit0 run, bit1 mode (1 = toggle, 0 = pulse), bit2 invert, bit3 clear (write-only, reads 0), bit4 interrupt enable. Bit0 reads back 1 while the block is running.
  - Address 3 is status: bit0 is the match flag.
  - Address 4 reads the current match-counter value.
  - Reads are combinational. With limit P, the prescaler ticks once every P+1 bus clocks.
- R2: The match counter advances only on prescaler ticks. It returns to zero on the tick where it equals T, so matches repeat every (T+1)(P+1) bus clocks. After a clear and a START write, the first match falls in cycle T(P+1)+P, counting cycle 0 as the first cycle after the START edge.
- R3: In pulse mode the output goes active in the cycle after a match. It stays active for exactly P+1 bus clocks.
- R4: In toggle mode the output changes level in the cycle after each match. The first change after a clear goes to the active level.
- R5: When the invert bit is 1, the output level is the inverse of what it would be with the bit at 0.
- R6: While stopped, neither divider moves, and `strobe_out` rests at the invert bit's value.
- R7: Writing control bit3 as 1 zeroes both dividers and the toggle and pulse state in one cycle. The bit needs no write back to 0. The prescale limit and terminal value are unchanged.
- R8: The match flag sets on every match. Writing 1 to status bit0 clears it; if a match comes in the same cycle, the set wins. `irq` is the flag AND the interrupt enable, and it follows the flag one cycle after the match edge or the clearing write.
- R9: A terminal value written during a run takes effect only at the next match or clear. The period in progress finishes with the old value.
- R10: After reset the block is stopped, and `strobe_out`, `irq` and every readable register are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| strobe_out | output | 1 | Programmable clock / strobe output |
| irq | output | 1 | Match interrupt request |

## Verification
Every strobe result is placed in time relative to the edge that captures the START write. That edge begins cycle 0. A match in cycle T(P+1)+P shows on `strobe_out` one cycle later. A pulse then stays active for P+1 cycles, and each later match follows (T+1)(P+1) cycles after the one before.

The driver computes these cycle numbers from P and T and queues the expected output level for each of them. The monitor samples two time units after each falling edge and compares only in the queued cycle; a queued cycle that passes without a comparison counts as a failure. Register reads are checked in the same cycle the address is applied, and `irq` is checked one cycle after the edge of the write that changed it.

// File: rtl/strobe_clk_pkg.sv
package strobe_clk_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PRESC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TERM   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

    localparam int B_RUN  = 0;
    localparam int B_MODE = 1;
    localparam int B_INV  = 2;
    localparam int B_CLR  = 3;
    localparam int B_IEN  = 4;
    localparam int B_FLAG = 0;

    typedef enum logic [0:0] {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_t;

endpackage

// File: rtl/strobe_clk_regs.sv
module strobe_clk_regs
    import strobe_clk_pkg::*;
#(
    parameter int PRESC_W = 8,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               match,
    input  logic [CNT_W-1:0]   count,
    output logic [PRESC_W-1:0] presc_lim,
    output logic [CNT_W-1:0]   term_next,
    output logic               running,
    output logic               clr,
    output logic               mode_tog,
    output logic               inv,
    output logic               irq
);

    run_state_t state_q, state_d;

    logic ctrl_wr;
    logic status_wr;
    logic ien_q;
    logic mode_q;
    logic inv_q;
    logic flag_q;
    logic [PRESC_W-1:0] presc_q;
    logic [CNT_W-1:0]   term_q;

    assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
    assign status_wr = bus_wr && (bus_addr == A_STATUS);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (ctrl_wr && bus_wdata[B_RUN]) begin
                    state_d = ST_RUNNING;
                end
            end
            ST_RUNNING: begin
                if (ctrl_wr && !bus_wdata[B_RUN]) begin
                    state_d = ST_STOPPED;
                end
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    // state outputs
    always_comb begin
        running = 1'b0;
        clr     = 1'b0;
        unique case (state_q)
            ST_STOPPED: running = 1'b0;
            ST_RUNNING: running = 1'b1;
            default:    running = 1'b0;
        endcase
        clr = ctrl_wr && bus_wdata[B_CLR];
    end

    // programmed values and control bits
    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            term_q  <= '0;
            ien_q   <= 1'b0;
            mode_q  <= 1'b0;
            inv_q   <= 1'b0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_PRESC: presc_q <= bus_wdata[PRESC_W-1:0];
                A_TERM:  term_q  <= bus_wdata[CNT_W-1:0];
                A_CTRL: begin
                    ien_q  <= bus_wdata[B_IEN];
                    mode_q <= bus_wdata[B_MODE];
                    inv_q  <= bus_wdata[B_INV];
                end
                default: ;
            endcase
        end
    end

    // sticky match flag, set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (status_wr && bus_wdata[B_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_PRESC:  bus_rdata = DATA_W'(presc_q);
            A_TERM:   bus_rdata = DATA_W'(term_q);
            A_CTRL: begin
                bus_rdata[B_RUN]  = running;
                bus_rdata[B_MODE] = mode_q;
                bus_rdata[B_INV]  = inv_q;
                bus_rdata[B_IEN]  = ien_q;
            end
            A_STATUS: bus_rdata[B_FLAG] = flag_q;
            A_COUNT:  bus_rdata = DATA_W'(count);
            default:  bus_rdata = '0;
        endcase
    end

    assign presc_lim = presc_q;
    assign term_next = term_q;
    assign mode_tog  = mode_q;
    assign inv       = inv_q;
    assign irq       = flag_q && ien_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        match |=> flag_q); // R8

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata[B_RUN]) |=> !running); // R6

endmodule

// File: rtl/strobe_clk_prescaler.sv
module strobe_clk_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               clr,
    input  logic [PRESC_W-1:0] limit,
    output logic               tick
);

    logic [PRESC_W-1:0] pcnt_q;

    // >= keeps the divider sane when the limit is lowered mid-run
    assign tick = run && (pcnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (clr) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(pcnt_q)); // R6

    AST_PRESC_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pcnt_q == '0)); // R7

endmodule

// File: rtl/strobe_clk_counter.sv
module strobe_clk_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] term_next,
    output logic [CNT_W-1:0] count,
    output logic             match
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_act_q;

    assign match = tick && !clr && (cnt_q == term_act_q);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            term_act_q <= '0;
        end else if (clr || match) begin
            cnt_q      <= '0;
            term_act_q <= term_next;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= term_act_q); // R2

    AST_CNT_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)); // R7

    AST_TERM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(clr || match) |=> $stable(term_act_q)); // R9

endmodule

// File: rtl/strobe_clk_shaper.sv
module strobe_clk_shaper (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic match,
    input  logic clr,
    input  logic mode_tog,
    input  logic inv,
    output logic strobe
);

    logic tog_q;
    logic pulse_q;
    logic raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else if (clr) begin
            tog_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (match) begin
                tog_q   <= !tog_q;
                pulse_q <= 1'b1;
            end else if (tick) begin
                pulse_q <= 1'b0;
            end
        end
    end

    always_comb begin
        raw = mode_tog ? tog_q : pulse_q;
        if (!run) begin
            raw = 1'b0;
        end
        strobe = raw ^ inv;
    end

    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
        match |=> (tog_q != $past(tog_q))); // R4

    AST_PULSE_SET: assert property (@(posedge clk) disable iff (rst)
        match |=> pulse_q); // R3

endmodule

// File: rtl/strobe_clock_gen.sv
module strobe_clock_gen
    import strobe_clk_pkg::*;
#(
    parameter int PRESC_W = 8,
    parameter int CNT_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [CNT_W-1:0]       bus_wdata,
    output logic [CNT_W-1:0]       bus_rdata,
    output logic                   strobe_out,
    output logic                   irq
);

    localparam int DATA_W = CNT_W;

    logic [PRESC_W-1:0] presc_lim;
    logic [CNT_W-1:0]   term_next;
    logic [CNT_W-1:0]   count;
    logic running;
    logic clr;
    logic mode_tog;
    logic inv;
    logic tick;
    logic match;

    strobe_clk_regs #(
        .PRESC_W (PRESC_W),
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .match     (match),
        .count     (count),
        .presc_lim (presc_lim),
        .term_next (term_next),
        .running   (running),
        .clr       (clr),
        .mode_tog  (mode_tog),
        .inv       (inv),
        .irq       (irq)
    );

    strobe_clk_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (running),
        .clr   (clr),
        .limit (presc_lim),
        .tick  (tick)
    );

    strobe_clk_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .clr       (clr),
        .term_next (term_next),
        .count     (count),
        .match     (match)
    );

    strobe_clk_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .tick     (tick),
        .match    (match),
        .clr      (clr),
        .mode_tog (mode_tog),
        .inv      (inv),
        .strobe   (strobe_out)
    );

    AST_NO_MATCH_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !running |-> !match); // R6

endmodule

// File: tb/strobe_clock_gen_bench.sv
module strobe_clock_gen_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [15:0] C_RUN  = 16'h0001;
    localparam logic [15:0] C_MODE = 16'h0002;
    localparam logic [15:0] C_INV  = 16'h0004;
    localparam logic [15:0] C_CLR  = 16'h0008;
    localparam logic [15:0] C_IEN  = 16'h0010;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        strobe_out;
    logic        irq;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } sb_item_t;

    sb_item_t sb[$];
    sb_item_t mon_item;

    strobe_clock_gen u_strobe_clock_gen (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .strobe_out (strobe_out),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_at(input int at, input logic v, input string tag);
        sb_item_t it;
        it.at  = at;
        it.val = v;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compares strobe_out exactly in the queued cycle
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            mon_item = sb.pop_front();
            if (mon_item.at < cyc) begin
                check(1'b0, {mon_item.tag, " missed cycle"}, cyc, mon_item.at);
            end else begin
                check(strobe_out === mon_item.val, mon_item.tag,
                      32'(strobe_out), 32'(mon_item.val));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] rd2;
        int c0;
        rst       = 1'b1;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(strobe_out === 1'b0, "R10 strobe", 32'(strobe_out), 0);
        check(irq === 1'b0, "R10 irq", 32'(irq), 0);
        bus_read(3'd2, rd);
        check(rd === 16'h0, "R10 ctrl", rd, 0);
        bus_read(3'd3, rd);
        check(rd === 16'h0, "R10 status", rd, 0);
        bus_read(3'd4, rd);
        check(rd === 16'h0, "R10 count", rd, 0);

        // R1 R2 R4: toggle, P=2 T=3, first match 11, period 12
        bus_write(3'd0, 16'd2);
        bus_write(3'd1, 16'd3);
        bus_read(3'd0, rd);
        check(rd === 16'd2, "R1 prescale readback", rd, 2);
        bus_write(3'd2, C_CLR | C_MODE);
        bus_write(3'd2, C_RUN | C_MODE);
        c0 = cyc;
        bus_read(3'd2, rd);
        check(rd[0] === 1'b1, "R1 run readback", rd, 1);
        expect_at(c0 + 11, 1'b0, "R1 before first match");
        expect_at(c0 + 12, 1'b1, "R1 after first match");
        expect_at(c0 + 23, 1'b1, "R2 before second match");
        expect_at(c0 + 24, 1'b0, "R2 after second match");
        expect_at(c0 + 36, 1'b1, "R4 third toggle");
        drain();

        // R6 stop: output rests low, counter holds
        bus_write(3'd2, C_MODE);
        check(strobe_out === 1'b0, "R6 rest level", 32'(strobe_out), 0);
        bus_read(3'd4, rd);
        repeat (5) @(negedge clk);
        bus_read(3'd4, rd2);
        check(rd2 === rd, "R6 counter holds", rd2, rd);
        // R5 R6 invert while stopped
        bus_write(3'd2, C_MODE | C_INV);
        check(strobe_out === 1'b1, "R5 R6 inverted rest", 32'(strobe_out), 1);

        // R7 clear keeps programmed values
        bus_write(3'd2, C_CLR | C_MODE);
        bus_read(3'd4, rd);
        check(rd === 16'h0, "R7 count zero", rd, 0);
        bus_read(3'd0, rd);
        check(rd === 16'd2, "R7 prescale kept", rd, 2);
        bus_read(3'd1, rd);
        check(rd === 16'd3, "R7 terminal kept", rd, 3);
        bus_read(3'd2, rd);
        check(rd[3] === 1'b0, "R7 clear bit reads 0", rd, 0);

        // R3 pulse, P=1 T=2: match 5, period 6, high for 2 cycles
        bus_write(3'd0, 16'd1);
        bus_write(3'd1, 16'd2);
        bus_write(3'd2, C_CLR);
        bus_write(3'd2, C_RUN);
        c0 = cyc;
        expect_at(c0 + 5,  1'b0, "R3 low before match");
        expect_at(c0 + 6,  1'b1, "R3 pulse start");
        expect_at(c0 + 7,  1'b1, "R3 pulse second cycle");
        expect_at(c0 + 8,  1'b0, "R3 pulse end");
        expect_at(c0 + 12, 1'b1, "R3 next pulse");
        expect_at(c0 + 14, 1'b0, "R3 next pulse end");
        drain();
        bus_write(3'd2, 16'h0);

        // R8 flag, enable gating, write-one-to-clear
        bus_read(3'd3, rd);
        check(rd[0] === 1'b1, "R8 flag set", rd, 1);
        check(irq === 1'b0, "R8 irq masked", 32'(irq), 0);
        bus_write(3'd2, C_IEN);
        check(irq === 1'b1, "R8 irq enabled", 32'(irq), 1);
        bus_write(3'd3, 16'h0001);
        check(irq === 1'b0, "R8 irq after clear", 32'(irq), 0);
        bus_read(3'd3, rd);
        check(rd[0] === 1'b0, "R8 flag cleared", rd, 0);

        // R5 inverted pulse
        bus_write(3'd2, C_CLR | C_INV);
        bus_write(3'd2, C_RUN | C_INV);
        c0 = cyc;
        expect_at(c0 + 5, 1'b1, "R5 inverted idle");
        expect_at(c0 + 6, 1'b0, "R5 inverted pulse");
        expect_at(c0 + 8, 1'b1, "R5 inverted pulse end");
        drain();
        bus_write(3'd2, 16'h0);

        // R9 deferred terminal: P=0 T=5, rewrite T=2 in cycle 0
        bus_write(3'd0, 16'd0);
        bus_write(3'd1, 16'd5);
        bus_write(3'd2, C_CLR | C_MODE);
        bus_write(3'd2, C_RUN | C_MODE);
        c0 = cyc;
        bus_write(3'd1, 16'd2);
        expect_at(c0 + 5,  1'b0, "R9 old period intact");
        expect_at(c0 + 6,  1'b1, "R9 first match at old T");
        expect_at(c0 + 8,  1'b1, "R9 before new match");
        expect_at(c0 + 9,  1'b0, "R9 new period");
        expect_at(c0 + 12, 1'b1, "R9 new period again");
        drain();
        bus_write(3'd2, 16'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule